// File: doc/BRIEF.md
# Locked Logo-Switching ROM Bank Mapper

This block is a cartridge memory mapper on the bus of an 8-bit CPU. Writes from the CPU to the lower half of the address space set three small registers: a base bank, a switchable bank and a bank mask. From those registers and the current CPU address it forms a physical ROM address for two 16 KiB windows. The lower window covers CPU 0x0000-0x3FFF and the upper window covers 0x4000-0x7FFF. The physical address is the bank number placed above the 14-bit offset inside the window.

The mapper comes out of reset locked. While it is locked, every read of the lower window has offset bit 7 forced high, which steers the boot code to an alternate logo image. A counter of ROM-access strobes releases the lock. Whether locked or not, lower-window addresses that land in the 0x0100-0x01FF header area have four of their low bits swapped, so that a header stored in scrambled order reads back in the right order. Reads of cartridge RAM space return all ones.

Top module: `lgm_top`

## Requirements
- R1: After reset the base and mask registers hold 0, the bank register holds 1, the mapper is locked and the access counter is 0.
- R2: Only CPU address bits 15..13 select a register: 000 is base, 001 is bank, 010 is mask. Writes with 011 (0x6000-0x7FFF) or with bit 15 set change no register, and address bits 12..0 are ignored.
- R3: A write of 0 to the bank register stores 1. Any other value is stored as written.
- R4: Base and mask writes are accepted only while bits 5 and 4 of the bank register are both 1. Otherwise they are dropped.
- R5: For an upper-window read (A14=1) the bank number is (base AND mask) OR (bank AND NOT mask).
- R6: For a lower-window read (A14=0) the bank number is (base AND mask) OR (lower latch AND NOT mask), with the lower latch fixed at 0.
- R7: Each cycle with rom_acc high is one access. If the counter already equals UNLOCK_AT (48), that access unlocks the mapper and already sees the unlocked mapping. Otherwise the counter increments. The unlock is therefore seen on access 49 and then holds until reset.
- R8: While locked, offset bit 7 of every lower-window address is forced to 1.
- R9: If the lower-window address after the bit-7 override has bits 15..8 equal to 0x01, bits 0, 1, 4 and 6 are rebuilt from the original address: new bit 0 is old bit 6, new bit 1 is old bit 4, new bit 4 is old bit 1 and new bit 6 is old bit 0. All other bits keep their values.
- R10: Upper-window offsets pass through unchanged, with neither the override nor the swap applied.
- R11: ram_rd_data always reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Single-cycle write strobe |
| rom_acc | input | 1 | Single-cycle ROM-access strobe |
| rom_addr | output | BANK_W+14 | Physical ROM address {bank, offset} |
| ram_rd_data | output | 8 | Cartridge RAM read data |

## Verification
The unlocking access and a bank-register write can fall in the same cycle. The bench provokes this by raising rom_acc for access 49 together with cpu_wr to 0x2000. In that cycle the lower-window address must already show the unlocked mapping, built from the old registers. On the next cycle the upper window must reflect the newly written bank.

// File: rtl/lgm_pkg.sv
package lgm_pkg;
   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_BANK = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int WIN_OFF_W = 14;

   function automatic reg_sel_e decode_sel(input logic [2:0] top3);
      case (top3)
         3'b000:  return SEL_BASE;
         3'b001:  return SEL_BANK;
         3'b010:  return SEL_MASK;
         default: return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/lgm_regs.sv
module lgm_regs
   import lgm_pkg::*;
#(
   parameter int BANK_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          wr_sel,
   input  logic [BANK_W-1:0] wr_data,
   output logic [BANK_W-1:0] base_q,
   output logic [BANK_W-1:0] mask_q,
   output logic [BANK_W-1:0] bank_q
);
   localparam logic [BANK_W-1:0] BANK_RST = BANK_W'(1);

   logic gate_open;
   assign gate_open = bank_q[5] & bank_q[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         bank_q <= BANK_RST;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_BASE: if (gate_open) base_q <= wr_data;
            SEL_MASK: if (gate_open) mask_q <= wr_data;
            SEL_BANK: bank_q <= (wr_data == '0) ? BANK_RST : wr_data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lgm_unlock.sv
module lgm_unlock #(
   parameter int UNLOCK_AT = 48
)(
   input  logic clk,
   input  logic rst_n,
   input  logic rom_acc,
   output logic unlocked_q,
   output logic unlocked_now,
   output logic [$clog2(UNLOCK_AT+1)-1:0] cnt_q
);
   localparam int CNT_W = $clog2(UNLOCK_AT+1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(UNLOCK_AT);

   logic at_limit;
   assign at_limit     = (cnt_q == LIMIT);
   assign unlocked_now = unlocked_q | (rom_acc & at_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         unlocked_q <= 1'b0;
      end else if (rom_acc) begin
         if (at_limit) unlocked_q <= 1'b1;
         else          cnt_q      <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lgm_xlate.sv
module lgm_xlate
   import lgm_pkg::*;
#(
   parameter int BANK_W       = 8,
   parameter bit HDR_SCRAMBLE = 1'b1
)(
   input  logic [15:0]                  cpu_addr,
   input  logic [BANK_W-1:0]            base_q,
   input  logic [BANK_W-1:0]            mask_q,
   input  logic [BANK_W-1:0]            bank_q,
   input  logic                         unlocked,
   output logic [BANK_W+WIN_OFF_W-1:0]  rom_addr
);
   localparam logic [BANK_W-1:0] LOW_LATCH = '0;

   logic [BANK_W-1:0] hi_bank, lo_bank;
   logic [15:0]       ovr, lo_addr;

   assign hi_bank = (base_q & mask_q) | (bank_q    & ~mask_q);
   assign lo_bank = (base_q & mask_q) | (LOW_LATCH & ~mask_q);

   always_comb begin
      ovr = cpu_addr;
      if (!unlocked) ovr[7] = 1'b1;
   end

   generate
      if (HDR_SCRAMBLE) begin : g_scr
         logic        in_hdr;
         logic [15:0] perm;
         assign in_hdr  = (ovr[15:8] == 8'h01);
         assign perm    = {ovr[15:7], cpu_addr[0], ovr[5], cpu_addr[1],
                           ovr[3:2], cpu_addr[4], cpu_addr[6]};
         assign lo_addr = in_hdr ? perm : ovr;
      end else begin : g_plain
         assign lo_addr = ovr;
      end
   endgenerate

   assign rom_addr = cpu_addr[14] ? {hi_bank, cpu_addr[WIN_OFF_W-1:0]}
                                  : {lo_bank, lo_addr[WIN_OFF_W-1:0]};
endmodule

// File: rtl/lgm_top.sv
module lgm_top
   import lgm_pkg::*;
#(
   parameter int BANK_W       = 8,
   parameter int UNLOCK_AT    = 48,
   parameter bit HDR_SCRAMBLE = 1'b1
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [15:0]                 cpu_addr,
   input  logic [7:0]                  cpu_data,
   input  logic                        cpu_wr,
   input  logic                        rom_acc,
   output logic [BANK_W+WIN_OFF_W-1:0] rom_addr,
   output logic [7:0]                  ram_rd_data
);
   localparam int CNT_W = $clog2(UNLOCK_AT+1);

   generate
      if (BANK_W < 6 || BANK_W > 8) begin : g_bad_bank_w
         $error("lgm_top: BANK_W must be 6..8");
      end
      if (UNLOCK_AT < 1) begin : g_bad_unlock
         $error("lgm_top: UNLOCK_AT must be positive");
      end
   endgenerate

   logic [BANK_W-1:0] base_q, mask_q, bank_q;
   logic              unlocked_q, unlocked_now;
   logic [CNT_W-1:0]  cnt_q;
   reg_sel_e          sel;

   assign sel         = decode_sel(cpu_addr[15:13]);
   assign ram_rd_data = 8'hFF;

   lgm_regs #(.BANK_W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .wr_sel(sel),
      .wr_data(cpu_data[BANK_W-1:0]),
      .base_q(base_q), .mask_q(mask_q), .bank_q(bank_q)
   );

   lgm_unlock #(.UNLOCK_AT(UNLOCK_AT)) u_unlock (
      .clk(clk), .rst_n(rst_n), .rom_acc(rom_acc),
      .unlocked_q(unlocked_q), .unlocked_now(unlocked_now), .cnt_q(cnt_q)
   );

   lgm_xlate #(.BANK_W(BANK_W), .HDR_SCRAMBLE(HDR_SCRAMBLE)) u_xlate (
      .cpu_addr(cpu_addr), .base_q(base_q), .mask_q(mask_q), .bank_q(bank_q),
      .unlocked(unlocked_now), .rom_addr(rom_addr)
   );
endmodule

// File: rtl/lgm_checker.sv
module lgm_checker #(
   parameter int BANK_W    = 8,
   parameter int UNLOCK_AT = 48
)(
   input logic                        clk,
   input logic                        rst_n,
   input logic [15:0]                 cpu_addr,
   input logic [7:0]                  cpu_data,
   input logic                        cpu_wr,
   input logic                        rom_acc,
   input logic [BANK_W+13:0]          rom_addr,
   input logic [BANK_W-1:0]           base_q,
   input logic [BANK_W-1:0]           mask_q,
   input logic [BANK_W-1:0]           bank_q,
   input logic                        unlocked_q,
   input logic [$clog2(UNLOCK_AT+1)-1:0] cnt_q
);
   localparam int CNT_W = $clog2(UNLOCK_AT+1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(UNLOCK_AT);

   // R2: writes outside the three register slots leave all registers alone
   a_r2_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && (cpu_addr[15] || cpu_addr[14:13] == 2'b11))
      |=> ($stable(base_q) && $stable(mask_q) && $stable(bank_q)));

   // R3: a zero write to the bank slot leaves 1
   a_r3_zero_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_data[BANK_W-1:0] == '0)
      |=> (bank_q == BANK_W'(1)));

   // R4: a base write with the gate closed is dropped
   a_r4_base_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'b000 && bank_q[5:4] != 2'b11)
      |=> $stable(base_q));

   // R4: a mask write with the gate closed is dropped
   a_r4_mask_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'b010 && bank_q[5:4] != 2'b11)
      |=> $stable(mask_q));

   // R7: the counter advances once per access while below the limit
   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_acc && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R7: once unlocked, the mapper stays unlocked
   a_r7_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked_q |=> unlocked_q);

   // R8: the locked lower window always has offset bit 7 high
   a_r8_locked_bit7: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked_q && !rom_acc && !cpu_addr[14]) |-> rom_addr[7]);

   // R10: the upper window offset passes through
   a_r10_upper_offset: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[14] |-> (rom_addr[13:0] == cpu_addr[13:0]));
endmodule

bind lgm_top lgm_checker #(.BANK_W(BANK_W), .UNLOCK_AT(UNLOCK_AT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
   .cpu_wr(cpu_wr), .rom_acc(rom_acc), .rom_addr(rom_addr),
   .base_q(base_q), .mask_q(mask_q), .bank_q(bank_q),
   .unlocked_q(unlocked_q), .cnt_q(cnt_q)
);

// File: tb/sim_lgm_top.sv
`timescale 1ns/1ps
module sim_lgm_top;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   cpu_addr = '0;
   logic [7:0]    cpu_data = '0;
   logic          cpu_wr = 1'b0;
   logic          rom_acc = 1'b0;
   logic [BW+13:0] rom_addr;
   logic [7:0]    ram_rd_data;

   int n_chk = 0;
   int n_fail = 0;

   // bench-side model state
   logic [7:0] m_base = 8'h00, m_mask = 8'h00, m_bank = 8'h01;
   bit         m_locked = 1'b1;

   always #2 clk = ~clk;

   lgm_top u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .rom_acc(rom_acc), .rom_addr(rom_addr),
      .ram_rd_data(ram_rd_data)
   );

   function automatic logic [21:0] expect_addr(input logic [15:0] a);
      logic [7:0]  bnk;
      logic [15:0] e;
      if (a[14]) begin
         bnk = (m_base & m_mask) | (m_bank & ~m_mask);
         return {bnk, a[13:0]};
      end
      bnk = m_base & m_mask;
      e = a;
      if (m_locked) e[7] = 1'b1;
      if (e[15:8] == 8'h01) begin
         e = e & ~16'h0053;
         e[0] = a[6];
         e[1] = a[4];
         e[4] = a[1];
         e[6] = a[0];
      end
      return {bnk, e[13:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
      case (a[15:13])
         3'b000: if (m_bank[5:4] == 2'b11) m_base = d;
         3'b010: if (m_bank[5:4] == 2'b11) m_mask = d;
         3'b001: m_bank = (d == 8'h00) ? 8'h01 : d;
         default: ;
      endcase
   endtask

   task automatic rd(input string req, input logic [15:0] a);
      @(negedge clk);
      cpu_addr = a;
      #1;
      check(req, 32'(rom_addr), 32'(expect_addr(a)));
   endtask

   task automatic access(input logic [15:0] a);
      @(negedge clk);
      cpu_addr = a; rom_acc = 1'b1;
      @(negedge clk);
      rom_acc = 1'b0;
   endtask

   task automatic t_reset;
      rd("R1 reset upper bank 1", 16'h4000);
      check("R1 reset upper literal", 32'(rom_addr), 32'h0_4000);
      rd("R1/R8 reset locked lower", 16'h0000);
      check("R8 locked literal", 32'(rom_addr), 32'h0_0080);
      check("R11 ram read", 32'(ram_rd_data), 32'hFF);
   endtask

   task automatic t_bank;
      wr(16'h2000, 8'h05);
      rd("R5 bank 05", 16'h4123);
      check("R5 literal", 32'(rom_addr), 32'h1_4123);
      wr(16'h3FFF, 8'h00);
      rd("R3 zero stores one (R2 low bits ignored)", 16'h7FFF);
      check("R3 literal", 32'(rom_addr), 32'h0_7FFF);
   endtask

   task automatic t_gate;
      wr(16'h2000, 8'h05);
      wr(16'h0000, 8'h0F);
      wr(16'h4000, 8'hF0);
      rd("R4 closed gate", 16'h4000);
      check("R4 closed literal", 32'(rom_addr), 32'h1_4000);
      wr(16'h2000, 8'h30);
      wr(16'h1234, 8'h0A);
      wr(16'h5FFF, 8'h0F);
      rd("R4/R5 open gate upper", 16'h4000);
      check("R5 masked literal", 32'(rom_addr), 32'hE_8000 | 32'h0_0000);
      rd("R6 lower bank base&mask", 16'h0000);
      check("R6 literal", 32'(rom_addr), 32'h2_8080);
   endtask

   task automatic t_ignored;
      wr(16'h6000, 8'hFF);
      wr(16'h7FFF, 8'h00);
      wr(16'h8000, 8'h00);
      wr(16'hA000, 8'h00);
      wr(16'hC000, 8'h00);
      rd("R2 ignored writes upper", 16'h4000);
      check("R2 literal", 32'(rom_addr), 32'hE_8000);
      wr(16'h2000, 8'h07);
      wr(16'h0000, 8'h05);
      rd("R4 base dropped after gate closes", 16'h0000);
      check("R4 base literal", 32'(rom_addr), 32'h2_8080);
   endtask

   task automatic t_header_locked;
      rd("R9 header 0101 locked", 16'h0101);
      check("R9 literal", 32'(rom_addr), 32'h2_81C0);
      rd("R9 header 0142 locked", 16'h0142);
      rd("R9 header 0113 locked", 16'h0113);
      rd("R9 header 01FF locked", 16'h01FF);
      rd("R9 outside header 0201", 16'h0201);
      rd("R10 upper untouched 4101", 16'h4101);
      check("R10 literal", 32'(rom_addr), 32'(expect_addr(16'h4101)));
      check("R10 offset literal", 32'(rom_addr[13:0]), 32'h0101);
   endtask

   task automatic t_unlock;
      for (int i = 0; i < 48; i++) access(16'h4000 + 16'(i));
      rd("R7 still locked after 48", 16'h0000);
      check("R7 locked literal", 32'(rom_addr), 32'h2_8080);
      // access 49 coincides with a bank write
      @(negedge clk);
      cpu_addr = 16'h2000; cpu_data = 8'h12; cpu_wr = 1'b1; rom_acc = 1'b1;
      m_locked = 1'b0;
      #1;
      check("R7 unlock seen on access 49", 32'(rom_addr), 32'h2_A000);
      @(negedge clk);
      cpu_wr = 1'b0; rom_acc = 1'b0;
      m_bank = 8'h12;
      rd("R5 bank written in unlock cycle", 16'h4000);
      check("R5 unlock-cycle literal", 32'(rom_addr), 32'h6_8000);
      access(16'h0000);
      rd("R7 stays unlocked", 16'h0000);
      check("R8 unlocked no override", 32'(rom_addr), 32'h2_8000);
      rd("R9 header 0101 unlocked", 16'h0101);
      check("R9 unlocked literal", 32'(rom_addr), 32'h2_8140);
      rd("R9 header 0150 unlocked", 16'h0150);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bank();
      t_gate();
      t_ignored();
      t_header_locked();
      t_unlock();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule